// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit APB-style register bus and runs on the same clock as that bus. Software selects one of sixteen power-of-two timeout periods and then turns the timer on. From then on it has to write a fixed key value to a restart register often enough. If it stops doing so, the block ends the run with a fixed-length system reset pulse. Once the timer is on, neither the enable nor the response mode can be changed again. Only the block's own reset input stops the counter.

There are two response modes. In the direct mode, the first expiry of the counter fires the reset pulse. In the warning mode, the first expiry raises an interrupt and reloads the counter. A second expiry while that interrupt is still pending fires the reset, so the reset comes two periods after the last kick. The interrupt is removed by a valid kick or by a read of the interrupt-clear address. Two period fields are provided. The first load after the enable takes its period from the initial-period field. Every later reload takes its period from the normal-period field.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, `irq_o` and `sys_rst_o` are low. The control word (0x00), the range word (0x04), the count (0x08) and the status word (0x10) all read 0. While the enable is off, no reset pulse is produced.
- R2: Control word 0x00 has bit 0 = enable and bit 1 = mode (0 direct, 1 warning). Once the enable is 1, writes to 0x00 change neither bit.
- R3: Period index i gives 2^(BASE_SHIFT+i) cycles, with BASE_SHIFT = 16 by default. The write that sets the enable loads the counter from the index in range bits 7:4. The count at 0x08 then reads that period minus 1 and falls by one each cycle.
- R4: In direct mode, `sys_rst_o` rises exactly one period after the last load edge, with no interrupt.
- R5: Writing exactly 0x76 to 0x0C while the timer runs reloads the counter from the index in range bits 3:0 and clears a pending interrupt.
- R6: Any other value written to 0x0C has no effect on the count or on the reset time.
- R7: In warning mode, `irq_o` rises one period after the load. `sys_rst_o` rises one further normal period later if no kick or clear happens in between.
- R8: Status 0x10 bit 0 reads 1 while the interrupt is pending, and reading it does not clear the interrupt. A read of 0x14 clears the interrupt, and the next expiry then acts as a first stage again.
- R9: `sys_rst_o` stays high for exactly RST_CYCLES cycles (default 8). After that the block stays expired: no further pulse, no interrupt, kicks are ignored and the count is frozen.
- R10: The parameter word at 0xF4 has bit 6 = 1 (fixed periods). The range word reads back its low 8 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| irq_o | output | 1 | Warning interrupt, level |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bound checker watches the following on every cycle:
- The enable never falls and the mode never moves once the timer is on.
- The first load after the enable matches the initial-period field.
- A reset pulse only rises after the count sat at zero.
- The interrupt exists only in warning mode.
- A valid kick always leaves the interrupt clear.
- The pulse has exactly the configured length.
- The count and the reset output stay frozen once expired.

The exact expiry times of both stages, the difference between the initial and the normal period, the rejection of wrong keys and the clear-on-read behaviour need the bench's directed sequences. In those sequences, edge counts are measured from the write that caused each load.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
   localparam logic [7:0]  OFS_CTRL  = 8'h00;
   localparam logic [7:0]  OFS_RANGE = 8'h04;
   localparam logic [7:0]  OFS_COUNT = 8'h08;
   localparam logic [7:0]  OFS_KICK  = 8'h0C;
   localparam logic [7:0]  OFS_STAT  = 8'h10;
   localparam logic [7:0]  OFS_ICLR  = 8'h14;
   localparam logic [7:0]  OFS_PARAM = 8'hF4;
   localparam logic [31:0] KICK_KEY  = 32'h0000_0076;
   localparam int          PARAM_FIXED_BIT = 6;
   localparam int          IDX_W = 4;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_WARN = 2'd1,
      ST_DONE = 2'd2
   } wdt_state_e;
endpackage

// File: rtl/twostage_wdt_regs.sv
module twostage_wdt_regs
   import twostage_wdt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   input  logic [CW-1:0]     count_i,
   input  logic              irq_i,
   output logic              ctrl_en_o,
   output logic              ctrl_mode_o,
   output logic [IDX_W-1:0]  period_idx_o,
   output logic [IDX_W-1:0]  init_idx_o,
   output logic              en_rise_o,
   output logic              kick_wr_o,
   output logic              iclr_o
);
   logic wr_acc, rd_acc;
   logic en_q, mode_q;
   logic [IDX_W-1:0] per_q, ini_q;

   assign wr_acc = psel & penable & pwrite;
   assign rd_acc = psel & penable & ~pwrite;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= 1'b0;
         per_q  <= '0;
         ini_q  <= '0;
      end else begin
         if (wr_acc && hit(paddr, OFS_CTRL) && !en_q) begin
            en_q   <= pwdata[0];
            mode_q <= pwdata[1];
         end
         if (wr_acc && hit(paddr, OFS_RANGE)) begin
            per_q <= pwdata[IDX_W-1:0];
            ini_q <= pwdata[2*IDX_W-1:IDX_W];
         end
      end
   end

   assign en_rise_o = wr_acc & hit(paddr, OFS_CTRL) & ~en_q & pwdata[0];
   assign kick_wr_o = wr_acc & hit(paddr, OFS_KICK) & (pwdata == KICK_KEY);
   assign iclr_o    = rd_acc & hit(paddr, OFS_ICLR);

   assign ctrl_en_o    = en_q;
   assign ctrl_mode_o  = mode_q;
   assign period_idx_o = per_q;
   assign init_idx_o   = ini_q;

   always_comb begin
      prdata = '0;
      if (psel) begin
         if (hit(paddr, OFS_CTRL))       prdata = {30'd0, mode_q, en_q};
         else if (hit(paddr, OFS_RANGE)) prdata = {24'd0, ini_q, per_q};
         else if (hit(paddr, OFS_COUNT)) prdata = 32'(count_i);
         else if (hit(paddr, OFS_STAT))  prdata = {31'd0, irq_i};
         else if (hit(paddr, OFS_PARAM)) prdata = 32'(1) << PARAM_FIXED_BIT;
      end
   end
endmodule

// File: rtl/twostage_wdt_downcnt.sv
module twostage_wdt_downcnt #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] count_o,
   output logic          zero_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (load)               cnt_q <= load_val;
      else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign count_o = cnt_q;
   assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/twostage_wdt_resp.sv
module twostage_wdt_resp
   import twostage_wdt_pkg::*;
#(
   parameter int RST_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode,
   input  logic expire,
   input  logic kick_ok,
   input  logic iclr,
   output logic irq_o,
   output logic halted_o,
   output logic stage_reload_o,
   output logic sys_rst_o
);
   wdt_state_e state_q, state_d;
   logic warned_eff, go_halt;

   always_comb begin
      warned_eff     = (state_q == ST_WARN) && !iclr;
      state_d        = state_q;
      stage_reload_o = 1'b0;
      go_halt        = 1'b0;
      if (state_q != ST_DONE) begin
         if (kick_ok) begin
            state_d = ST_RUN;
         end else if (expire) begin
            if (mode && !warned_eff) begin
               state_d        = ST_WARN;
               stage_reload_o = 1'b1;
            end else begin
               state_d = ST_DONE;
               go_halt = 1'b1;
            end
         end else if (iclr && state_q == ST_WARN) begin
            state_d = ST_RUN;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   assign irq_o    = (state_q == ST_WARN);
   assign halted_o = (state_q == ST_DONE);

   generate
      if (RST_CYCLES == 1) begin : g_pulse_single
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= go_halt;
         end
         assign sys_rst_o = pulse_q;
      end else begin : g_pulse_count
         localparam int PW = $clog2(RST_CYCLES + 1);
         logic [PW-1:0] pcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pcnt_q <= '0;
            else if (go_halt)        pcnt_q <= PW'(RST_CYCLES);
            else if (pcnt_q != '0)   pcnt_q <= pcnt_q - 1'b1;
         end
         assign sys_rst_o = (pcnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
   import twostage_wdt_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int BASE_SHIFT  = 16,
   parameter int NUM_PERIODS = 16,
   parameter int RST_CYCLES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              irq_o,
   output logic              sys_rst_o
);
   localparam int CW = BASE_SHIFT + NUM_PERIODS;

   generate
      if (NUM_PERIODS != (1 << IDX_W)) begin : g_bad_periods
         $error("NUM_PERIODS must match the 4-bit index field");
      end
      if (CW > 32 || BASE_SHIFT < 1) begin : g_bad_shift
         $error("BASE_SHIFT out of range for a 32-bit count");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must cover the 8-bit register offsets");
      end
      if (RST_CYCLES < 1) begin : g_bad_pulse
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic             ctrl_en, ctrl_mode;
   logic [IDX_W-1:0] period_idx, init_idx;
   logic             en_rise, kick_wr, iclr;
   logic             kick_ok, halted, run, expire, stage_reload;
   logic             ext_load, load_any, cnt_zero;
   logic [CW-1:0]    cnt_q, load_val;
   logic [CW-1:0]    period_tab [NUM_PERIODS];

   for (genvar gi = 0; gi < NUM_PERIODS; gi++) begin : g_tab
      assign period_tab[gi] = CW'((64'd1 << (BASE_SHIFT + gi)) - 64'd1);
   end

   twostage_wdt_regs #(.ADDR_W(ADDR_W), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .count_i(cnt_q), .irq_i(irq_o),
      .ctrl_en_o(ctrl_en), .ctrl_mode_o(ctrl_mode),
      .period_idx_o(period_idx), .init_idx_o(init_idx),
      .en_rise_o(en_rise), .kick_wr_o(kick_wr), .iclr_o(iclr)
   );

   assign run      = ctrl_en & ~halted;
   assign kick_ok  = kick_wr & run;
   assign ext_load = en_rise | kick_ok;
   assign expire   = run & cnt_zero & ~ext_load;
   assign load_any = ext_load | stage_reload;
   assign load_val = en_rise ? period_tab[init_idx] : period_tab[period_idx];

   twostage_wdt_downcnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .run(run), .load(load_any), .load_val(load_val),
      .count_o(cnt_q), .zero_o(cnt_zero)
   );

   twostage_wdt_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
      .clk(clk), .rst_n(rst_n),
      .mode(ctrl_mode), .expire(expire), .kick_ok(kick_ok), .iclr(iclr),
      .irq_o(irq_o), .halted_o(halted), .stage_reload_o(stage_reload),
      .sys_rst_o(sys_rst_o)
   );
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk #(
   parameter int BASE_SHIFT  = 16,
   parameter int NUM_PERIODS = 16,
   parameter int RST_CYCLES  = 8
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              en,
   input logic                              mode,
   input logic [BASE_SHIFT+NUM_PERIODS-1:0] cnt,
   input logic [3:0]                        init_idx,
   input logic                              irq,
   input logic                              sys_rst,
   input logic                              halted,
   input logic                              kick_ok
);
   localparam int CW = BASE_SHIFT + NUM_PERIODS;
   localparam int HW = $clog2(RST_CYCLES + 2) + 1;

   logic [HW-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_cnt <= '0;
      else if (sys_rst) hi_cnt <= hi_cnt + 1'b1;
      else              hi_cnt <= '0;
   end

   assert_en_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> en);
   assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(mode));
   assert_init_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> cnt == CW'((64'd1 << (BASE_SHIFT + int'(init_idx))) - 64'd1));
   assert_rst_after_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(cnt) == '0);
   assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      kick_ok |=> !irq);
   assert_irq_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> mode);
   assert_pulse_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |-> hi_cnt < HW'(RST_CYCLES));
   assert_pulse_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst) |-> $past(hi_cnt) == HW'(RST_CYCLES - 1));
   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !sys_rst) |=> (!sys_rst && !irq && $stable(cnt)));
endmodule

bind twostage_wdt twostage_wdt_chk #(
   .BASE_SHIFT(BASE_SHIFT), .NUM_PERIODS(NUM_PERIODS), .RST_CYCLES(RST_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctrl_en), .mode(ctrl_mode), .cnt(cnt_q),
   .init_idx(init_idx), .irq(irq_o), .sys_rst(sys_rst_o), .halted(halted),
   .kick_ok(kick_ok)
);

// File: tb/twostage_wdt_bench.sv
`timescale 1ns/1ps
module twostage_wdt_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        irq_o, sys_rst_o;

   int total = 0, bad = 0;
   int cyc = 0;
   int wr_cyc, rd_cyc;
   int rst_seen = 0, rst_cyc = 0, rst_hi = 0;
   int irq_seen = 0, irq_cyc = 0;
   logic [31:0] rd;

   twostage_wdt #(.BASE_SHIFT(4)) u_twostage_wdt (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .irq_o(irq_o), .sys_rst_o(sys_rst_o)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   always @(negedge clk) begin
      if (sys_rst_o && rst_seen == 0) begin rst_seen = 1; rst_cyc = cyc; end
      if (sys_rst_o) rst_hi = rst_hi + 1;
      if (irq_o && irq_seen == 0) begin irq_seen = 1; irq_cyc = cyc; end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_seen = 0; rst_hi = 0; irq_seen = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      wr_cyc = cyc;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      #1 d = prdata; rd_cyc = cyc;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic wait_rst(input int limit);
      for (int i = 0; i < limit && rst_seen == 0; i++) @(negedge clk);
   endtask

   task automatic wait_irq(input int limit);
      for (int i = 0; i < limit && irq_seen == 0; i++) @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 irq after reset", int'(irq_o), 0);
      chk("R1 sys_rst after reset", int'(sys_rst_o), 0);
      bus_read(8'h00, rd); chk("R1 ctrl read", int'(rd), 0);
      bus_read(8'h04, rd); chk("R1 range read", int'(rd), 0);
      bus_read(8'h08, rd); chk("R1 count read", int'(rd), 0);
      bus_read(8'h10, rd); chk("R1 status read", int'(rd), 0);
      repeat (60) @(negedge clk);
      chk("R1 no pulse while disabled", rst_seen, 0);
   endtask

   task automatic t_params();
      do_reset();
      bus_read(8'hF4, rd); chk("R10 fixed-period bit", int'(rd[6]), 1);
      bus_write(8'h04, 32'h0000_005A);
      bus_read(8'h04, rd); chk("R10 range readback", int'(rd), 32'h5A);
      bus_write(8'h04, 32'hFFFF_FF21);
      bus_read(8'h04, rd); chk("R10 range upper bits dropped", int'(rd), 32'h21);
   endtask

   task automatic t_direct_mode();
      int e;
      do_reset();
      bus_write(8'h04, 32'h10);
      bus_write(8'h00, 32'h1);
      e = wr_cyc;
      bus_read(8'h08, rd);
      chk("R3 count after enable", int'(rd), 31 - (rd_cyc - e));
      wait_rst(300);
      chk("R3 R4 reset time uses initial period", rst_cyc - e, 32);
      chk("R4 no interrupt in direct mode", irq_seen, 0);
      repeat (20) @(negedge clk);
      chk("R9 pulse length", rst_hi, 8);
      bus_write(8'h0C, 32'h76);
      repeat (200) @(negedge clk);
      chk("R9 no second pulse", rst_hi, 8);
      chk("R9 no interrupt when expired", int'(irq_o), 0);
      bus_read(8'h08, rd);
      chk("R9 count frozen", int'(rd), 0);
   endtask

   task automatic t_kick();
      int k;
      do_reset();
      bus_write(8'h04, 32'h02);
      bus_write(8'h00, 32'h1);
      repeat (6) @(negedge clk);
      bus_write(8'h0C, 32'h76);
      k = wr_cyc;
      bus_read(8'h08, rd);
      chk("R5 count after kick", int'(rd), 63 - (rd_cyc - k));
      wait_rst(300);
      chk("R5 reset one normal period after kick", rst_cyc - k, 64);
   endtask

   task automatic t_bad_key();
      int e;
      do_reset();
      bus_write(8'h04, 32'h20);
      bus_write(8'h00, 32'h1);
      e = wr_cyc;
      repeat (10) @(negedge clk);
      bus_write(8'h0C, 32'h75);
      bus_write(8'h0C, 32'h176);
      bus_read(8'h08, rd);
      chk("R6 count unchanged by wrong key", int'(rd), 63 - (rd_cyc - e));
      wait_rst(300);
      chk("R6 reset time unchanged by wrong key", rst_cyc - e, 64);
   endtask

   task automatic t_sticky();
      int e;
      do_reset();
      bus_write(8'h04, 32'h10);
      bus_write(8'h00, 32'h1);
      e = wr_cyc;
      bus_write(8'h00, 32'h0);
      bus_write(8'h00, 32'h2);
      bus_read(8'h00, rd);
      chk("R2 ctrl unchanged once enabled", int'(rd), 1);
      wait_rst(300);
      chk("R2 counter still runs", rst_cyc - e, 32);
      chk("R2 mode not switched to warning", irq_seen, 0);
   endtask

   task automatic t_two_stage();
      int e;
      do_reset();
      bus_write(8'h04, 32'h01);
      bus_write(8'h00, 32'h3);
      e = wr_cyc;
      wait_irq(300);
      chk("R7 interrupt after first period", irq_cyc - e, 16);
      bus_read(8'h10, rd);
      chk("R8 status reads pending", int'(rd[0]), 1);
      chk("R8 status read keeps interrupt", int'(irq_o), 1);
      wait_rst(300);
      chk("R7 reset after second stage", rst_cyc - e, 48);
   endtask

   task automatic t_kick_in_warning();
      int k;
      do_reset();
      bus_write(8'h04, 32'h01);
      bus_write(8'h00, 32'h3);
      wait_irq(300);
      bus_write(8'h0C, 32'h76);
      k = wr_cyc;
      chk("R5 kick clears interrupt", int'(irq_o), 0);
      irq_seen = 0;
      wait_irq(300);
      chk("R5 R7 interrupt one period after kick", irq_cyc - k, 32);
      wait_rst(300);
      chk("R7 reset two periods after kick", rst_cyc - k, 64);
   endtask

   task automatic t_read_clear();
      int e;
      do_reset();
      bus_write(8'h04, 32'h01);
      bus_write(8'h00, 32'h3);
      e = wr_cyc;
      wait_irq(300);
      bus_read(8'h14, rd);
      chk("R8 clear read drops interrupt", int'(irq_o), 0);
      bus_read(8'h10, rd);
      chk("R8 status after clear", int'(rd), 0);
      irq_seen = 0;
      wait_irq(300);
      chk("R8 next expiry is first stage again", irq_cyc - e, 48);
      chk("R8 no reset at second expiry", rst_seen, 0);
      wait_rst(300);
      chk("R8 R7 reset one stage later", rst_cyc - e, 80);
   endtask

   initial begin
      #(5.0 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_params();
      t_direct_mode();
      t_kick();
      t_bad_key();
      t_sticky();
      t_two_stage();
      t_kick_in_warning();
      t_read_clear();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule